// File: doc/BRIEF.md
# Selective Repeat Receive Tracker

This block sits on the receive side of a reliable packet transport and keeps track of which sequence numbers have arrived. Each incoming header presents one sequence number. The block holds a 64-position arrival bitmap. The bitmap is anchored at the oldest sequence number that has not yet arrived, called the expected base. Any new number that falls inside the window is handed straight to the consumer, in arrival order. The consumer never waits for an earlier packet that is still missing.

When an arrival lands beyond every number seen so far and leaves a hole behind it, the block raises a selective negative acknowledgement. That message carries the current base and a 64-bit mask, and a set bit in the mask names one missing number. Numbers that are already recorded are never requested again. Stale numbers and repeated numbers are flagged as duplicates. Numbers too far ahead are dropped and counted. The base moves forward one position per clock for as long as the entry at the base has arrived.

Top module: `sr_rx_tracker`

## Requirements
- R1: After a synchronous reset, the following hold: the expected base is 0, the bitmap is empty, fwd_valid, dup_flag, oow_flag and nack_valid are all 0, and the drop counter is 0.
- R2: A sequence number whose modular offset from the base is below 64, and whose bit is not yet set, is recorded. One clock after it is presented, fwd_valid is 1 and fwd_psn holds that number, even when earlier numbers are still missing.
- R3: A sequence number whose bit is already set is reported by a one-cycle pulse on dup_flag and is not forwarded. A number whose 16-bit modular offset from the base is 32768 or more (it is older than the base) is handled the same way.
- R4: A sequence number whose modular offset is from 64 up to 32767 is dropped. The drop is reported by a one-cycle pulse on oow_flag, and oow_cnt increases by one (it saturates at its maximum). The number is not forwarded.
- R5: The frontier is one past the highest offset received so far. An accepted arrival whose offset is above the frontier raises a NACK. The NACK carries the base after this cycle's update, and a mask in which bit i is set exactly when number base+i is unreceived and lies below the new frontier.
- R6: An arrival that fills a hole, or that lands exactly at the frontier, raises no NACK.
- R7: While the bitmap entry at the base is set, the base advances by exactly one per clock and the bitmap shifts with it. exp_psn shows the base.
- R8: A pending NACK keeps its valid, base and mask unchanged until nack_ready is high. If a further gap opens while a NACK is pending, exactly one follow-up NACK is issued after the handshake. Its mask lists every hole that is still open at that moment.
- R9: All offsets are computed modulo 2^16, so the window, the NACK mask and base advance work unchanged across the wrap from 65535 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | An incoming header is present this cycle |
| pkt_psn | input | 16 | Sequence number of the incoming header |
| fwd_valid | output | 1 | Registered pulse: packet forwarded to consumer |
| fwd_psn | output | 16 | Sequence number of the forwarded packet |
| dup_flag | output | 1 | Registered pulse: duplicate or stale packet discarded |
| oow_flag | output | 1 | Registered pulse: packet beyond window dropped |
| oow_cnt | output | 16 | Saturating count of beyond-window drops |
| exp_psn | output | 16 | Current expected base |
| nack_valid | output | 1 | Selective NACK is offered |
| nack_ready | input | 1 | Consumer of the NACK accepts it |
| nack_base | output | 16 | Sequence number that mask bit 0 refers to |
| nack_mask | output | 64 | Bit i set: number nack_base+i is missing |

## Verification
The assertions check the following on every cycle:
- at most one of forward, duplicate and drop fires per arrival;
- a forwarded number lay inside the window of the previous cycle;
- the base never moves by more than one per clock;
- the drop counter changes only with a drop;
- a pending NACK never names an empty mask and stays frozen while stalled.

The exact mask contents, the absence of a NACK when a hole is filled, the single follow-up after a stall, and behaviour across the sequence wrap can only be shown by the bench's scenarios. Those scenarios compare against mask values worked out by hand for each arrival pattern.

// File: rtl/sr_rx_pkg.sv
package sr_rx_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_FWD  = 2'd1,
    CLS_DUP  = 2'd2,
    CLS_OOW  = 2'd3
  } pkt_cls_e;
endpackage

// File: rtl/sr_psn_classify.sv
// Sorts one arriving sequence number against the current window.
module sr_psn_classify
  import sr_rx_pkg::*;
#(
  parameter int PSN_W = 16,
  parameter int WIN   = 64,
  parameter int IDX_W = $clog2(WIN)
) (
  input  logic             in_valid,
  input  logic [PSN_W-1:0] in_psn,
  input  logic [PSN_W-1:0] base,
  input  logic [WIN-1:0]   bitmap,
  output pkt_cls_e         cls,
  output logic [IDX_W-1:0] idx
);
  localparam logic [PSN_W-1:0] WIN_V = PSN_W'(WIN);

  logic [PSN_W-1:0] off;
  logic             behind;
  logic             inwin;
  logic             seen;

  always_comb begin
    off    = in_psn - base;           // modular distance
    behind = off[PSN_W-1];            // older than base
    inwin  = (off < WIN_V);
    idx    = off[IDX_W-1:0];
    seen   = bitmap[idx];
    if (!in_valid)          cls = CLS_NONE;
    else if (behind)        cls = CLS_DUP;
    else if (!inwin)        cls = CLS_OOW;
    else if (seen)          cls = CLS_DUP;
    else                    cls = CLS_FWD;
  end
endmodule

// File: rtl/sr_win_state.sv
// Holds base, arrival bitmap and frontier; slides one step per clock.
module sr_win_state #(
  parameter int PSN_W = 16,
  parameter int WIN   = 64,
  parameter int IDX_W = $clog2(WIN),
  parameter int TOP_W = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [IDX_W-1:0] idx,
  output logic [PSN_W-1:0] base,
  output logic [WIN-1:0]   bitmap,
  output logic [PSN_W-1:0] base_n,
  output logic [WIN-1:0]   bitmap_n,
  output logic [TOP_W-1:0] top_n,
  output logic             gap
);
  logic [TOP_W-1:0] top;
  logic [WIN-1:0]   bm_set;
  logic [TOP_W-1:0] idx_w;
  logic [TOP_W-1:0] top_set;
  logic             slide;

  always_comb begin
    idx_w   = TOP_W'(idx);
    slide   = bitmap[0];
    bm_set  = bitmap | (accept ? (WIN'(1) << idx) : '0);
    bitmap_n = slide ? (bm_set >> 1) : bm_set;
    base_n  = base + (slide ? PSN_W'(1) : '0);
    top_set = (accept && (idx_w >= top)) ? idx_w + TOP_W'(1) : top;
    top_n   = top_set - (slide ? TOP_W'(1) : '0);
    gap     = accept && (idx_w > top);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base   <= '0;
      bitmap <= '0;
      top    <= '0;
    end else begin
      base   <= base_n;
      bitmap <= bitmap_n;
      top    <= top_n;
    end
  end
endmodule

// File: rtl/sr_nack_gen.sv
// Builds and holds selective NACK messages with a valid/ready handshake.
module sr_nack_gen #(
  parameter int PSN_W = 16,
  parameter int WIN   = 64,
  parameter int TOP_W = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gap,
  input  logic [PSN_W-1:0] base_n,
  input  logic [WIN-1:0]   bitmap_n,
  input  logic [TOP_W-1:0] top_n,
  input  logic             nack_ready,
  output logic             nack_valid,
  output logic [PSN_W-1:0] nack_base,
  output logic [WIN-1:0]   nack_mask
);
  logic [WIN-1:0] below;
  logic [WIN-1:0] holes;
  logic           redo;
  logic           fire;
  logic           free;

  always_comb begin
    for (int i = 0; i < WIN; i++) begin
      below[i] = (TOP_W'(i) < top_n);
    end
    holes = ~bitmap_n & below;
    fire  = nack_valid && nack_ready;
    free  = !nack_valid || nack_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nack_valid <= 1'b0;
      nack_base  <= '0;
      nack_mask  <= '0;
      redo       <= 1'b0;
    end else begin
      if (fire) nack_valid <= 1'b0;
      if ((gap || redo) && free) begin
        if (holes != '0) begin
          nack_valid <= 1'b1;
          nack_base  <= base_n;
          nack_mask  <= holes;
        end
        redo <= 1'b0;
      end else if (gap) begin
        redo <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sr_rx_tracker.sv
module sr_rx_tracker
  import sr_rx_pkg::*;
#(
  parameter int PSN_W = 16,
  parameter int WIN   = 64,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_valid,
  input  logic [PSN_W-1:0] pkt_psn,
  output logic             fwd_valid,
  output logic [PSN_W-1:0] fwd_psn,
  output logic             dup_flag,
  output logic             oow_flag,
  output logic [CNT_W-1:0] oow_cnt,
  output logic [PSN_W-1:0] exp_psn,
  output logic             nack_valid,
  input  logic             nack_ready,
  output logic [PSN_W-1:0] nack_base,
  output logic [WIN-1:0]   nack_mask
);
  localparam int IDX_W = $clog2(WIN);
  localparam int TOP_W = $clog2(WIN + 1);

  pkt_cls_e         cls;
  logic [IDX_W-1:0] idx;
  logic [PSN_W-1:0] base;
  logic [WIN-1:0]   bitmap;
  logic [PSN_W-1:0] base_n;
  logic [WIN-1:0]   bitmap_n;
  logic [TOP_W-1:0] top_n;
  logic             gap;

  sr_psn_classify #(.PSN_W(PSN_W), .WIN(WIN), .IDX_W(IDX_W)) u_cls (
    .in_valid (pkt_valid),
    .in_psn   (pkt_psn),
    .base     (base),
    .bitmap   (bitmap),
    .cls      (cls),
    .idx      (idx)
  );

  sr_win_state #(.PSN_W(PSN_W), .WIN(WIN), .IDX_W(IDX_W), .TOP_W(TOP_W)) u_win (
    .clk      (clk),
    .rst      (rst),
    .accept   (cls == CLS_FWD),
    .idx      (idx),
    .base     (base),
    .bitmap   (bitmap),
    .base_n   (base_n),
    .bitmap_n (bitmap_n),
    .top_n    (top_n),
    .gap      (gap)
  );

  sr_nack_gen #(.PSN_W(PSN_W), .WIN(WIN), .TOP_W(TOP_W)) u_nack (
    .clk        (clk),
    .rst        (rst),
    .gap        (gap),
    .base_n     (base_n),
    .bitmap_n   (bitmap_n),
    .top_n      (top_n),
    .nack_ready (nack_ready),
    .nack_valid (nack_valid),
    .nack_base  (nack_base),
    .nack_mask  (nack_mask)
  );

  assign exp_psn = base;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid <= 1'b0;
      fwd_psn   <= '0;
      dup_flag  <= 1'b0;
      oow_flag  <= 1'b0;
      oow_cnt   <= '0;
    end else begin
      fwd_valid <= (cls == CLS_FWD);
      dup_flag  <= (cls == CLS_DUP);
      oow_flag  <= (cls == CLS_OOW);
      if (cls == CLS_FWD) fwd_psn <= pkt_psn;
      if ((cls == CLS_OOW) && (oow_cnt != '1)) oow_cnt <= oow_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sr_rx_tracker_chk.sv
module sr_rx_tracker_chk #(
  parameter int PSN_W = 16,
  parameter int WIN   = 64,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             fwd_valid,
  input logic [PSN_W-1:0] fwd_psn,
  input logic             dup_flag,
  input logic             oow_flag,
  input logic [CNT_W-1:0] oow_cnt,
  input logic [PSN_W-1:0] exp_psn,
  input logic             nack_valid,
  input logic             nack_ready,
  input logic [PSN_W-1:0] nack_base,
  input logic [WIN-1:0]   nack_mask
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fwd_valid, dup_flag, oow_flag}));                         // R3
  AST_FWD_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> ((fwd_psn - $past(exp_psn)) < PSN_W'(WIN)));          // R2
  AST_BASE_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((exp_psn - $past(exp_psn)) <= PSN_W'(1)));                // R7
  AST_DROP_COUNT: assert property (@(posedge clk) disable iff (rst)
    !oow_flag |-> $stable(oow_cnt));                                    // R4
  AST_NACK_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    nack_valid |-> (nack_mask != '0));                                  // R5
  AST_NACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (nack_valid && !nack_ready) |=>
      (nack_valid && $stable(nack_base) && $stable(nack_mask)));        // R8
endmodule

bind sr_rx_tracker sr_rx_tracker_chk #(.PSN_W(PSN_W), .WIN(WIN), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fwd_valid  (fwd_valid),
  .fwd_psn    (fwd_psn),
  .dup_flag   (dup_flag),
  .oow_flag   (oow_flag),
  .oow_cnt    (oow_cnt),
  .exp_psn    (exp_psn),
  .nack_valid (nack_valid),
  .nack_ready (nack_ready),
  .nack_base  (nack_base),
  .nack_mask  (nack_mask)
);

// File: tb/sim_sr_rx_tracker.sv
module sim_sr_rx_tracker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pkt_valid = 1'b0;
  logic [15:0] pkt_psn = '0;
  logic        nack_ready = 1'b1;
  logic        fwd_valid, dup_flag, oow_flag, nack_valid;
  logic [15:0] fwd_psn, oow_cnt, exp_psn, nack_base;
  logic [63:0] nack_mask;

  int total = 0;
  int bad = 0;
  int nack_seen = 0;
  logic [15:0] last_base;
  logic [63:0] last_mask;

  always #10 clk = ~clk;

  sr_rx_tracker u0 (
    .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_psn(pkt_psn),
    .fwd_valid(fwd_valid), .fwd_psn(fwd_psn), .dup_flag(dup_flag),
    .oow_flag(oow_flag), .oow_cnt(oow_cnt), .exp_psn(exp_psn),
    .nack_valid(nack_valid), .nack_ready(nack_ready),
    .nack_base(nack_base), .nack_mask(nack_mask)
  );

  always @(negedge clk) begin
    if (!rst && nack_valid && nack_ready) begin
      nack_seen = nack_seen + 1;
      last_base = nack_base;
      last_mask = nack_mask;
    end
  end

  // psn, class (1 fwd, 2 dup, 3 drop), nack expected, mask, base after settling
  typedef struct packed {
    logic [15:0] psn;
    logic [1:0]  cls;
    logic        nk;
    logic [63:0] mask;
    logic [15:0] base;
  } vec_t;

  localparam vec_t TBL [15] = '{
    '{16'd0,     2'd1, 1'b0, 64'h0,                   16'd1},
    '{16'd1,     2'd1, 1'b0, 64'h0,                   16'd2},
    '{16'd4,     2'd1, 1'b1, 64'h3,                   16'd2},
    '{16'd5,     2'd1, 1'b0, 64'h0,                   16'd2},
    '{16'd7,     2'd1, 1'b1, 64'h13,                  16'd2},
    '{16'd4,     2'd2, 1'b0, 64'h0,                   16'd2},
    '{16'd2,     2'd1, 1'b0, 64'h0,                   16'd3},
    '{16'd3,     2'd1, 1'b0, 64'h0,                   16'd6},
    '{16'd1,     2'd2, 1'b0, 64'h0,                   16'd6},
    '{16'd70,    2'd3, 1'b0, 64'h0,                   16'd6},
    '{16'd6,     2'd1, 1'b0, 64'h0,                   16'd8},
    '{16'd71,    2'd1, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 16'd8},
    '{16'd71,    2'd2, 1'b0, 64'h0,                   16'd8},
    '{16'd32776, 2'd2, 1'b0, 64'h0,                   16'd8},
    '{16'd32775, 2'd3, 1'b0, 64'h0,                   16'd8}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] p);
    @(negedge clk);
    pkt_valid = 1'b1;
    pkt_psn   = p;
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (70) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad = bad + 1;
    total = total + 1;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n0;
    do_reset();
    // R1 reset state
    chk(exp_psn == 0, "R1 base", 64'(exp_psn), 0);
    chk(!fwd_valid && !dup_flag && !oow_flag, "R1 pulses", {fwd_valid, dup_flag, oow_flag}, 0);
    chk(!nack_valid, "R1 nack", 64'(nack_valid), 0);
    chk(oow_cnt == 0, "R1 count", 64'(oow_cnt), 0);

    // table: R2 forward, R3 duplicate, R4 drop, R5 mask, R6 no nack, R7 advance
    for (int i = 0; i < 15; i++) begin
      n0 = nack_seen;
      send(TBL[i].psn);
      chk(fwd_valid == (TBL[i].cls == 2'd1), "R2 fwd_valid", 64'(fwd_valid), 64'(TBL[i].cls == 2'd1));
      chk(dup_flag == (TBL[i].cls == 2'd2), "R3 dup_flag", 64'(dup_flag), 64'(TBL[i].cls == 2'd2));
      chk(oow_flag == (TBL[i].cls == 2'd3), "R4 oow_flag", 64'(oow_flag), 64'(TBL[i].cls == 2'd3));
      if (TBL[i].cls == 2'd1)
        chk(fwd_psn == TBL[i].psn, "R2 fwd_psn", 64'(fwd_psn), 64'(TBL[i].psn));
      settle();
      chk(exp_psn == TBL[i].base, "R7 base", 64'(exp_psn), 64'(TBL[i].base));
      chk((nack_seen - n0) == int'(TBL[i].nk), "R5/R6 nack count", 64'(nack_seen - n0), 64'(TBL[i].nk));
      if (TBL[i].nk) begin
        chk(last_mask == TBL[i].mask, "R5 mask", last_mask, TBL[i].mask);
        chk(last_base == 16'd2 || last_base == 16'd8, "R5 base", 64'(last_base), 64'(TBL[i].base));
      end
    end
    chk(oow_cnt == 16'd2, "R4 count", 64'(oow_cnt), 2);

    // R8 stalled NACK then single follow-up
    do_reset();
    chk(oow_cnt == 0, "R1 count after reset", 64'(oow_cnt), 0);
    nack_ready = 1'b0;
    n0 = nack_seen;
    send(16'd2);
    chk(nack_valid && nack_mask == 64'h3 && nack_base == 0, "R8 first nack", nack_mask, 64'h3);
    send(16'd5);
    repeat (3) @(negedge clk);
    chk(nack_valid && nack_mask == 64'h3, "R8 held", nack_mask, 64'h3);
    nack_ready = 1'b1;
    repeat (5) @(negedge clk);
    chk(nack_seen - n0 == 2, "R8 count", 64'(nack_seen - n0), 2);
    chk(last_mask == 64'h1B && last_base == 0, "R8 follow-up mask", last_mask, 64'h1B);

    // R9 wraparound
    do_reset();
    n0 = nack_seen;
    @(negedge clk);
    for (int k = 0; k < 65534; k++) begin
      pkt_valid = 1'b1;
      pkt_psn   = 16'(k);
      @(negedge clk);
    end
    pkt_valid = 1'b0;
    settle();
    chk(exp_psn == 16'd65534, "R9 base near wrap", 64'(exp_psn), 65534);
    chk(nack_seen == n0, "R6 in-order no nack", 64'(nack_seen - n0), 0);
    send(16'd2);
    chk(fwd_valid && fwd_psn == 16'd2, "R9 fwd across wrap", 64'(fwd_psn), 2);
    settle();
    chk(nack_seen - n0 == 1 && last_mask == 64'hF && last_base == 16'd65534, "R9 wrap mask", last_mask, 64'hF);
    send(16'd65535);
    send(16'd65534);
    settle();
    chk(exp_psn == 16'd0, "R9 base wraps", 64'(exp_psn), 0);
    send(16'd0);
    send(16'd1);
    settle();
    chk(exp_psn == 16'd3, "R7 base after fill", 64'(exp_psn), 3);
    chk(nack_seen - n0 == 1, "R6 fill no nack", 64'(nack_seen - n0), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule